// File: doc/BRIEF.md
# Clock Source Select and Divider

This block produces the system operating clock. It takes two free-running sources, a main oscillator clock and an on-chip oscillator clock, picks one, and divides it by 1, 2, 4 or 8. Two small registers control it: a 4-bit mode register that holds the divide code, a stop bit for the main oscillator and the source select, and a 1-bit register that stops the on-chip oscillator. The two stop bits leave the block as oscillator-enable outputs, which run the oscillator cells.

Hardware blocks any write that would stop the oscillator that is driving the clock, or that would move the clock onto an oscillator that is stopped. Only the offending bit is blocked, and the other bits of the same write still take effect. Software starts an oscillator, waits for it to settle, and then switches to it. The source switch is glitch-free. A new divide ratio takes effect only at the end of a full output period.

Top module: `clk_source_divider`

## Requirements
- R1: While reset is asserted and after it is released, the mode register reads 1101 and the on-chip stop register reads 0. Both main_osc_en and onchip_osc_en are high.
- R2: Once reset is released, clk_out runs at the on-chip clock divided by 8.
- R3: A write with wr_addr=0 loads wr_data[3:2] into the divide code. Code 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8. The clk_out period then equals the source period times that ratio.
- R4: Mode bit 0 selects the source: 0 is the main clock and 1 is the on-chip clock. clk_out is derived from the selected source.
- R5: Mode bit 1 set to 1 stops the main oscillator, so main_osc_en is low. A write with wr_addr=1 puts wr_data[0] into the on-chip stop bit, and 1 drives onchip_osc_en low. Each of these takes effect only where R6 and R7 allow it.
- R6: A mode write that sets bit 1 is blocked, and bit 1 keeps its old value, when the main clock is the current source or the resulting source. The other bits still apply.
- R7: A write of 1 to the on-chip stop bit is ignored while the on-chip clock is the source.
- R8: A mode write that changes the source to an oscillator whose stop bit is set leaves bit 0 unchanged. The divide code and bit 1 still apply.
- R9: While the source is changing, clk_out shows no high or low phase shorter than half a period of the faster source.
- R10: A change of divide code takes effect at the end of an output period, so no clk_out phase is shorter than half a source period.
- R11: While wr_en is low, neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the mode register, 1 selects the on-chip stop register |
| wr_data | input | 4 | Write data |
| rd_mode | output | 4 | Mode register contents |
| rd_osc_stop | output | 1 | On-chip oscillator stop bit |
| main_osc_en | output | 1 | High keeps the main oscillator running |
| onchip_osc_en | output | 1 | High keeps the on-chip oscillator running |
| clk_main | input | 1 | Main oscillator clock |
| clk_onchip | input | 1 | On-chip oscillator clock |
| clk_out | output | 1 | Selected and divided operating clock |

## Verification
The hardest case to reach is a blocked write that arrives while the other oscillator is already stopped. Only a software sequence gets there: first stop one oscillator, then request a switch to it or request that the active one stop. The bench's oscillator models stop toggling whenever their enable output drops. A protection failure therefore freezes or distorts clk_out, and the period measurement catches it, as well as the register readback. Glitches at a handover show up in an edge-to-edge pulse monitor. That monitor runs through directed switches between very different clock rates and through random sequences that mix source changes with ratio changes.

// File: rtl/cksel_pkg.sv
package cksel_pkg;
  // Source select encoding held in mode bit 0
  localparam logic SRC_MAIN   = 1'b0;
  localparam logic SRC_ONCHIP = 1'b1;
  // Register address encoding on wr_addr
  localparam logic ADDR_MODE  = 1'b0;
  localparam logic ADDR_OSC   = 1'b1;
  // Bit positions within the mode register
  localparam int   MODE_SRC_BIT  = 0;
  localparam int   MODE_STOP_BIT = 1;
  localparam int   MODE_DIV_LSB  = 2;
endpackage

// File: rtl/cksel_sync.sv
module cksel_sync #(
  parameter int                STAGES  = 2,
  parameter int                WIDTH   = 1,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cksel_regs.sv
module cksel_regs
  import cksel_pkg::*;
#(
  parameter int DIV_W = 2,
  localparam int MODE_W = DIV_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [MODE_W-1:0] wr_data_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              osc_stop_o
);
  // Reset: slowest ratio, main running, on-chip source
  localparam logic [MODE_W-1:0] MODE_RST = {{DIV_W{1'b1}}, 1'b0, SRC_ONCHIP};

  logic [MODE_W-1:0] mode_q, mode_d;
  logic              osc_q, osc_d;
  logic              cur_src, cur_mstop, w_src, w_mstop;
  logic              tgt_running, new_src, new_mstop;
  logic              wr_mode, wr_osc;

  assign wr_mode = wr_en_i && (wr_addr_i == ADDR_MODE);
  assign wr_osc  = wr_en_i && (wr_addr_i == ADDR_OSC);

  always_comb begin
    cur_src   = mode_q[MODE_SRC_BIT];
    cur_mstop = mode_q[MODE_STOP_BIT];
    w_src     = wr_data_i[MODE_SRC_BIT];
    w_mstop   = wr_data_i[MODE_STOP_BIT];
    // Destination must be running before the select may move to it
    tgt_running = (w_src == SRC_MAIN) ? !cur_mstop : !osc_q;
    new_src     = ((w_src == cur_src) || tgt_running) ? w_src : cur_src;
    // Main may not stop while it drives, or will drive, the clock
    new_mstop   = (w_mstop && ((cur_src == SRC_MAIN) || (new_src == SRC_MAIN)))
                  ? cur_mstop : w_mstop;
    mode_d = mode_q;
    osc_d  = osc_q;
    if (wr_mode) begin
      mode_d = {wr_data_i[MODE_W-1:MODE_DIV_LSB], new_mstop, new_src};
    end
    if (wr_osc) begin
      osc_d = (wr_data_i[0] && (cur_src == SRC_ONCHIP)) ? osc_q : wr_data_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      osc_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      osc_q  <= osc_d;
    end
  end

  assign mode_o     = mode_q;
  assign osc_stop_o = osc_q;
endmodule

// File: rtl/cksel_glitchless_mux.sv
module cksel_glitchless_mux #(
  parameter int STAGES = 2
) (
  input  logic clk_a_i,    // selected when sel_i = 0
  input  logic clk_b_i,    // selected when sel_i = 1
  input  logic rst_ni,
  input  logic sel_i,
  output logic clk_o
);
  logic [1:0] clk_in;
  logic [1:0] gate_en;

  assign clk_in = {clk_b_i, clk_a_i};

  for (genvar g = 0; g < 2; g++) begin : g_branch
    logic want;
    logic loc_rst_n;
    logic req_sync;
    logic gate_q;

    // Request only after the other branch has released its gate
    assign want = (sel_i == (g == 1)) && !gate_en[1-g];

    cksel_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_rst (
      .clk_i (clk_in[g]),
      .rst_ni(rst_ni),
      .d_i   (1'b1),
      .q_o   (loc_rst_n)
    );

    cksel_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_req (
      .clk_i (clk_in[g]),
      .rst_ni(loc_rst_n),
      .d_i   (want),
      .q_o   (req_sync)
    );

    // Gate changes only while its clock is low
    always_ff @(negedge clk_in[g] or negedge loc_rst_n) begin
      if (!loc_rst_n) begin
        gate_q <= 1'b0;
      end else begin
        gate_q <= req_sync;
      end
    end

    assign gate_en[g] = gate_q;
  end

  assign clk_o = |(clk_in & gate_en);
endmodule

// File: rtl/cksel_divider.sv
module cksel_divider #(
  parameter int DIV_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] ratio_i,   // exponent: divide by 2**ratio_i
  output logic             clk_o
);
  localparam int MAX_EXP = (1 << DIV_W) - 1;
  localparam int CNT_W   = (MAX_EXP > 1) ? MAX_EXP - 1 : 1;
  localparam int HW      = MAX_EXP + 1;

  logic             loc_rst_n;
  logic [DIV_W-1:0] ratio_s;
  logic [DIV_W-1:0] k_q, k_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic [HW-1:0]    half;
  logic             q_q, q_d;
  logic             thru_q;
  logic             wrap, period_end;

  cksel_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (loc_rst_n)
  );

  cksel_sync #(.STAGES(STAGES), .WIDTH(DIV_W), .RST_VAL({DIV_W{1'b1}})) u_ratio (
    .clk_i (clk_i),
    .rst_ni(loc_rst_n),
    .d_i   (ratio_i),
    .q_o   (ratio_s)
  );

  always_comb begin
    half       = (HW'(1) << k_q) >> 1;
    half_m1    = CNT_W'(half - HW'(1));
    wrap       = (cnt_q == half_m1);
    period_end = (k_q == '0) || (q_q && wrap);
    k_d   = k_q;
    cnt_d = cnt_q;
    q_d   = q_q;
    if (period_end) begin
      k_d   = ratio_s;
      cnt_d = '0;
      q_d   = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      q_d   = !q_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge loc_rst_n) begin
    if (!loc_rst_n) begin
      k_q   <= {DIV_W{1'b1}};
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      k_q   <= k_d;
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  // Output path switches while the input clock is low
  always_ff @(negedge clk_i or negedge loc_rst_n) begin
    if (!loc_rst_n) begin
      thru_q <= 1'b0;
    end else begin
      thru_q <= (k_q == '0);
    end
  end

  assign clk_o = thru_q ? clk_i : q_q;
endmodule

// File: rtl/clk_source_divider.sv
module clk_source_divider
  import cksel_pkg::*;
#(
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int MODE_W     = DIV_W + 2
) (
  input  logic              clk_reg,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] rd_mode,
  output logic              rd_osc_stop,
  output logic              main_osc_en,
  output logic              onchip_osc_en,
  input  logic              clk_main,
  input  logic              clk_onchip,
  output logic              clk_out
);
  logic              rst_reg_n;
  logic [MODE_W-1:0] mode;
  logic              osc_stop;
  logic              clk_mux;

  cksel_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_rst_reg (
    .clk_i (clk_reg),
    .rst_ni(rst_n),
    .d_i   (1'b1),
    .q_o   (rst_reg_n)
  );

  cksel_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i     (clk_reg),
    .rst_ni    (rst_reg_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .mode_o    (mode),
    .osc_stop_o(osc_stop)
  );

  cksel_glitchless_mux #(.STAGES(SYNC_STAGES)) u_mux (
    .clk_a_i(clk_main),
    .clk_b_i(clk_onchip),
    .rst_ni (rst_n),
    .sel_i  (mode[MODE_SRC_BIT]),
    .clk_o  (clk_mux)
  );

  cksel_divider #(.DIV_W(DIV_W), .STAGES(SYNC_STAGES)) u_div (
    .clk_i  (clk_mux),
    .rst_ni (rst_n),
    .ratio_i(mode[MODE_W-1:MODE_DIV_LSB]),
    .clk_o  (clk_out)
  );

  assign rd_mode       = mode;
  assign rd_osc_stop   = osc_stop;
  assign main_osc_en   = !mode[MODE_STOP_BIT];
  assign onchip_osc_en = !osc_stop;
endmodule

// File: rtl/clk_source_divider_chk.sv
module clk_source_divider_chk #(
  parameter int MODE_W = 4
) (
  input logic              clk_reg,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [MODE_W-1:0] wr_data,
  input logic [MODE_W-1:0] rd_mode,
  input logic              rd_osc_stop,
  input logic              main_osc_en,
  input logic              onchip_osc_en
);
  // R6: main source never has its oscillator stopped
  p_main_kept_r6: assert property (@(posedge clk_reg) disable iff (!rst_sync_n)
    (rd_mode[0] == 1'b0) |-> main_osc_en);

  // R7: on-chip source never has its oscillator stopped
  p_onchip_kept_r7: assert property (@(posedge clk_reg) disable iff (!rst_sync_n)
    rd_mode[0] |-> onchip_osc_en);

  // R8: the select only moves onto an oscillator that was already running
  p_switch_running_r8: assert property (@(posedge clk_reg) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && ($past(rd_mode[0]) != rd_mode[0]))
      |-> (rd_mode[0] ? $past(onchip_osc_en) : $past(main_osc_en)));

  // R3: a mode write always loads the divide code
  p_ratio_load_r3: assert property (@(posedge clk_reg) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(wr_en) && ($past(wr_addr) == 1'b0))
      |-> (rd_mode[MODE_W-1:2] == $past(wr_data[MODE_W-1:2])));

  // R11: no write, no change
  p_idle_hold_r11: assert property (@(posedge clk_reg) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$past(wr_en)) |-> ($stable(rd_mode) && $stable(rd_osc_stop)));
endmodule

bind clk_source_divider clk_source_divider_chk #(.MODE_W(MODE_W)) u_chk (
  .clk_reg      (clk_reg),
  .rst_sync_n   (rst_reg_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .rd_mode      (rd_mode),
  .rd_osc_stop  (rd_osc_stop),
  .main_osc_en  (main_osc_en),
  .onchip_osc_en(onchip_osc_en)
);

// File: tb/clk_source_divider_test.sv
module clk_source_divider_test;
  localparam time CLK_PERIOD  = 10;
  localparam time MAIN_HALF   = 7;
  localparam time ONCHIP_HALF = 20;
  localparam time SETTLE      = 1000;

  logic       clk_reg = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] rd_mode;
  logic       rd_osc_stop, main_osc_en, onchip_osc_en;
  logic       clk_main = 1'b0;
  logic       clk_onchip = 1'b0;
  logic       clk_out;

  int errors = 0;
  int checks = 0;
  int glitches = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  time last_edge = 0;
  logic [3:0] m_mode;
  logic       m_osc;

  clk_source_divider uut (
    .clk_reg(clk_reg), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_mode(rd_mode), .rd_osc_stop(rd_osc_stop),
    .main_osc_en(main_osc_en), .onchip_osc_en(onchip_osc_en),
    .clk_main(clk_main), .clk_onchip(clk_onchip), .clk_out(clk_out)
  );

  always #(CLK_PERIOD/2) clk_reg = ~clk_reg;

  // Oscillator models stop toggling when their enable drops
  initial forever begin
    #(MAIN_HALF);
    clk_main = main_osc_en ? ~clk_main : 1'b0;
  end
  initial forever begin
    #(ONCHIP_HALF);
    clk_onchip = onchip_osc_en ? ~clk_onchip : 1'b0;
  end

  // Pulse monitor: R9 and R10 forbid phases shorter than half the faster source
  always @(clk_out) begin
    if (mon_on && (($time - last_edge) < MAIN_HALF)) glitches++;
    last_edge = $time;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model_write(input bit addr, input logic [3:0] d);
    logic src, mstop, tgt_ok;
    if (addr == 1'b0) begin
      tgt_ok = d[0] ? !m_osc : !m_mode[1];
      src    = ((d[0] == m_mode[0]) || tgt_ok) ? d[0] : m_mode[0];
      mstop  = (d[1] && (m_mode[0] == 1'b0 || src == 1'b0)) ? m_mode[1] : d[1];
      m_mode = {d[3:2], mstop, src};
    end else begin
      m_osc = (d[0] && m_mode[0]) ? m_osc : d[0];
    end
  endfunction

  task automatic write_reg(input bit addr, input logic [3:0] d);
    @(negedge clk_reg);
    wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(negedge clk_reg);
    wr_en = 1'b0;
    model_write(addr, d);
  endtask

  task automatic check_regs(input string req);
    check(rd_mode == m_mode, req, "mode register", rd_mode, m_mode);
    check(rd_osc_stop == m_osc, req, "on-chip stop", rd_osc_stop, m_osc);
    check(main_osc_en == !m_mode[1], req, "main_osc_en", main_osc_en, !m_mode[1]);
    check(onchip_osc_en == !m_osc, req, "onchip_osc_en", onchip_osc_en, !m_osc);
  endtask

  task automatic check_period(input string req);
    time t0, p1, p2;
    longint exp;
    exp = longint'(m_mode[0] ? 2*ONCHIP_HALF : 2*MAIN_HALF) << m_mode[3:2];
    #(SETTLE);
    @(posedge clk_out); t0 = $time;
    @(posedge clk_out); p1 = $time - t0; t0 = $time;
    @(posedge clk_out); p2 = $time - t0;
    check(longint'(p1) == exp && longint'(p2) == exp, req, "clk_out period",
          longint'(p1), exp);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] d;
    bit a;
    void'($urandom(32'h5eed_c10c));
    m_mode = 4'b1101; m_osc = 1'b0;
    repeat (5) @(negedge clk_reg);
    check_regs("R1 in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk_reg);
    check_regs("R1 after reset");
    check_period("R2 reset clock onchip/8");
    mon_on = 1'b1;

    // Directed: switch to main through
    write_reg(1'b0, 4'b0000); check_regs("R4 select main");
    check_period("R3 R4 main divide by 1");
    write_reg(1'b1, 4'b0001); check_regs("R5 stop on-chip while on main");
    write_reg(1'b0, 4'b0101); check_regs("R8 select stopped on-chip");
    check_period("R8 ratio applied, source kept");
    write_reg(1'b0, 4'b0110); check_regs("R6 stop main while main source");
    check_period("R6 main still running");
    write_reg(1'b1, 4'b0000); check_regs("R5 restart on-chip");
    write_reg(1'b0, 4'b1011); check_regs("R6 stop main while leaving it");
    check_period("R4 on-chip divide by 4");
    write_reg(1'b0, 4'b1011); check_regs("R5 stop main on on-chip source");
    write_reg(1'b1, 4'b0001); check_regs("R7 stop active on-chip");
    check_period("R7 on-chip still running");
    write_reg(1'b0, 4'b0000); check_regs("R8 select stopped main");
    check_period("R8 on-chip through");
    write_reg(1'b0, 4'b0000); check_regs("R4 main after restart");
    check_period("R3 main through again");
    repeat (20) @(negedge clk_reg);
    check_regs("R11 idle hold");
    check(glitches == 0, "R9", "short pulses during directed switching", glitches, 0);

    // Ratio-only changes on each source
    glitches = 0;
    for (int i = 0; i < 12; i++) begin
      d = 4'($urandom_range(0, 15));
      d[1:0] = m_mode[1:0];
      if (i == 6) begin
        write_reg(1'b0, {2'b11, 1'b0, 1'b1});
        check_regs("R4 move to on-chip");
        d[1:0] = m_mode[1:0];
      end
      write_reg(1'b0, d); check_regs("R3 ratio write");
      check_period("R3 ratio period");
    end
    check(glitches == 0, "R10", "short pulses on ratio change", glitches, 0);

    // Mixed random writes
    glitches = 0;
    for (int i = 0; i < 24; i++) begin
      a = 1'($urandom_range(0, 1));
      d = 4'($urandom_range(0, 15));
      write_reg(a, d); check_regs("R5 R6 R7 R8 random write");
      check_period("R3 R4 random period");
    end
    check(glitches == 0, "R9", "short pulses in random sequence", glitches, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule